// File: doc/BRIEF.md
# Windowed Integer Register File

This block is a 32-bit integer register file in which the 32 architectural register numbers an instruction names are translated into a larger physical array through a current window pointer. Eight global registers are shared by every window. Each window owns sixteen physical registers: eight locals and eight ins. The eight outs of a window are the same physical registers as the eight ins of the window one below it. A caller can therefore place arguments in its outs, and the callee finds them in its ins without any copy.

The file has two combinational read ports and one write port. Two commands move the pointer. A save enters a callee by stepping the pointer down by one. A restore returns to the caller by stepping it up by one. Both steps wrap modulo the window count. An input bitmap marks windows as unusable. If a save would land on a marked window, an overflow trap is raised for one cycle. If a restore would land on a marked window, an underflow trap is raised for one cycle. When a trap is raised, the pointer does not move. Spilling windows to memory is left to trap software outside this block.

The window count is a parameter, from 2 to 32, which gives 40 to 520 physical registers.

Top module: `regwin_rf`

## Requirements
- R1: While reset is held and just after it is released, the pointer is 0, both trap outputs are low, and every register reads 0.
- R2: Architectural register 0 always reads 0. A write to it has no effect, including on a read of register 0 in the same cycle.
- R3: Architectural registers 1 to 7 are globals: one physical copy each, visible unchanged from every window.
- R4: Architectural registers 16 to 23 are locals private to the current window, and 24 to 31 are its ins. Reads return the addressed register of the current window in the same cycle.
- R5: Architectural registers 8 to 15 are outs. Out k of window w is the same physical register as in k of window (w-1) mod N. A value written to out k is therefore read as in k after a save, and a value in in k is read as out k after a restore.
- R6: A save with the restore input low moves the pointer from w to (w-1) mod N, visible from the next cycle, provided bit (w-1) mod N of the invalid bitmap is 0.
- R7: A restore with the save input low moves the pointer from w to (w+1) mod N, visible from the next cycle, provided bit (w+1) mod N of the invalid bitmap is 0.
- R8: A save whose target window has its invalid bit set leaves the pointer unchanged and drives the overflow trap high for exactly the next cycle.
- R9: A restore whose target window has its invalid bit set leaves the pointer unchanged and drives the underflow trap high for exactly the next cycle.
- R10: A save and a restore asserted in the same cycle cancel each other: the pointer does not change and no trap is raised.
- R11: A read of the physical register being written in the same cycle returns the new write data. The value is kept from the next cycle onward.
- R12: A write issued in the same cycle as a save or restore goes to the window that was current before the pointer moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 5 | Architectural register number, read port A |
| rd_a_data | output | 32 | Read data, port A (combinational) |
| rd_b_idx | input | 5 | Architectural register number, read port B |
| rd_b_data | output | 32 | Read data, port B (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Architectural register number to write |
| wr_data | input | 32 | Write data |
| save_req | input | 1 | Step the window pointer down (subroutine entry) |
| restore_req | input | 1 | Step the window pointer up (subroutine return) |
| win_invalid | input | NWIN | One bit per window; a set bit makes that window an illegal target |
| cwp | output | 5 | Current window pointer |
| ovf_trap | output | 1 | One-cycle pulse: a save targeted an invalid window |
| unf_trap | output | 1 | One-cycle pulse: a restore targeted an invalid window |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a write and a read of the same register. The bench drives a write and both read addresses to one register together. It then samples the read data before the clock edge, where the new data must appear, and again after the edge, where the stored value must remain. Register 0 gets the same treatment and must stay 0.

The second pair is a write and a save. The bench issues them together, reads the target local in the new window, where it must be empty, and then restores. The written value must then be found in the original window.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    localparam int XLEN      = 32;
    localparam int ARCH_W    = 5;
    localparam int GROUP     = 8;
    localparam int GLOBALS   = GROUP;
    localparam int WIN_REGS  = 2 * GROUP;
    localparam int PTR_OUT_W = 5;

    // Architectural register groups, decoded from index bits [4:3].
    typedef enum logic [1:0] {
        GRP_GLOBAL = 2'd0,
        GRP_OUT    = 2'd1,
        GRP_LOCAL  = 2'd2,
        GRP_IN     = 2'd3
    } grp_e;

    typedef struct packed {
        logic              en;
        logic [XLEN-1:0]   data;
    } wr_req_t;

endpackage

// File: rtl/regwin_map.sv
module regwin_map
    import regwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int IW   = $clog2(NWIN),
    parameter int PW   = 8
) (
    input  logic [IW-1:0]     cwp,
    input  logic [ARCH_W-1:0] arch_idx,
    output logic [PW-1:0]     phys_idx
);

    logic [IW-1:0] below;
    int            slot;

    always_comb begin
        below = (cwp == '0) ? IW'(NWIN - 1) : cwp - 1'b1;
        slot  = int'(arch_idx[2:0]);
        case (arch_idx[4:3])
            GRP_GLOBAL: phys_idx = PW'(slot);
            // outs alias the ins of the window one below
            GRP_OUT:    phys_idx = PW'(GLOBALS + int'(below) * WIN_REGS + slot);
            GRP_LOCAL:  phys_idx = PW'(GLOBALS + int'(cwp) * WIN_REGS + GROUP + slot);
            default:    phys_idx = PW'(GLOBALS + int'(cwp) * WIN_REGS + slot);
        endcase
    end

endmodule

// File: rtl/regwin_ptr.sv
module regwin_ptr
    import regwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int IW   = $clog2(NWIN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            save_req,
    input  logic            restore_req,
    input  logic [NWIN-1:0] win_invalid,
    output logic [IW-1:0]   cwp,
    output logic            ovf,
    output logic            unf
);

    typedef struct packed {
        logic [IW-1:0] cwp;
        logic          ovf;
        logic          unf;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    logic [IW-1:0] down_d, up_d;

    always_comb begin
        st_d     = st_q;
        st_d.ovf = 1'b0;
        st_d.unf = 1'b0;
        down_d   = (st_q.cwp == '0) ? IW'(NWIN - 1) : st_q.cwp - 1'b1;
        up_d     = (st_q.cwp == IW'(NWIN - 1)) ? '0 : st_q.cwp + 1'b1;
        if (save_req && !restore_req) begin
            if (win_invalid[down_d]) st_d.ovf = 1'b1;
            else                     st_d.cwp = down_d;
        end else if (restore_req && !save_req) begin
            if (win_invalid[up_d])   st_d.unf = 1'b1;
            else                     st_d.cwp = up_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cwp = st_q.cwp;
    assign ovf = st_q.ovf;
    assign unf = st_q.unf;

endmodule

// File: rtl/regwin_store.sv
module regwin_store
    import regwin_pkg::*;
#(
    parameter int PHYS = 136,
    parameter int PW   = $clog2(PHYS),
    parameter int NRD  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  wr_req_t         wr,
    input  logic [PW-1:0]   wr_phys,
    input  logic [PW-1:0]   rd_phys [NRD],
    output logic [XLEN-1:0] rd_data [NRD]
);

    logic [XLEN-1:0] mem_d [PHYS];
    logic [XLEN-1:0] mem_q [PHYS];
    logic            wr_live;

    // physical slot 0 is global 0: never stored
    assign wr_live = wr.en && (wr_phys != '0);

    always_comb begin
        mem_d = mem_q;
        if (wr_live) mem_d[wr_phys] = wr.data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PHYS; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            if (rd_phys[p] == '0)                     rd_data[p] = '0;
            else if (wr_live && wr_phys == rd_phys[p]) rd_data[p] = wr.data;
            else                                      rd_data[p] = mem_q[rd_phys[p]];
        end
    end

endmodule

// File: rtl/regwin_rf.sv
module regwin_rf
    import regwin_pkg::*;
#(
    parameter int NWIN = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ARCH_W-1:0]    rd_a_idx,
    output logic [XLEN-1:0]      rd_a_data,
    input  logic [ARCH_W-1:0]    rd_b_idx,
    output logic [XLEN-1:0]      rd_b_data,
    input  logic                 wr_en,
    input  logic [ARCH_W-1:0]    wr_idx,
    input  logic [XLEN-1:0]      wr_data,
    input  logic                 save_req,
    input  logic                 restore_req,
    input  logic [NWIN-1:0]      win_invalid,
    output logic [PTR_OUT_W-1:0] cwp,
    output logic                 ovf_trap,
    output logic                 unf_trap
);

    localparam int IW    = $clog2(NWIN);
    localparam int PHYS  = GLOBALS + WIN_REGS * NWIN;
    localparam int PW    = $clog2(PHYS);
    localparam int NRD   = 2;
    localparam int NMAP  = NRD + 1;

    logic [IW-1:0]     cwp_int;
    logic [ARCH_W-1:0] arch_sel [NMAP];
    logic [PW-1:0]     phys_sel [NMAP];
    logic [PW-1:0]     rd_phys  [NRD];
    logic [XLEN-1:0]   rd_data  [NRD];
    wr_req_t           wr;

    regwin_ptr #(.NWIN(NWIN), .IW(IW)) ptr_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .save_req    (save_req),
        .restore_req (restore_req),
        .win_invalid (win_invalid),
        .cwp         (cwp_int),
        .ovf         (ovf_trap),
        .unf         (unf_trap)
    );

    assign arch_sel[0] = rd_a_idx;
    assign arch_sel[1] = rd_b_idx;
    assign arch_sel[2] = wr_idx;

    // all translations use the pointer value before any move this cycle
    for (genvar m = 0; m < NMAP; m++) begin : g_map
        regwin_map #(.NWIN(NWIN), .IW(IW), .PW(PW)) map_i (
            .cwp      (cwp_int),
            .arch_idx (arch_sel[m]),
            .phys_idx (phys_sel[m])
        );
    end

    assign rd_phys[0] = phys_sel[0];
    assign rd_phys[1] = phys_sel[1];
    assign wr.en      = wr_en;
    assign wr.data    = wr_data;

    regwin_store #(.PHYS(PHYS), .PW(PW), .NRD(NRD)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (wr),
        .wr_phys (phys_sel[2]),
        .rd_phys (rd_phys),
        .rd_data (rd_data)
    );

    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];
    assign cwp       = PTR_OUT_W'(cwp_int);

endmodule

// File: rtl/regwin_rf_chk.sv
module regwin_rf_chk
    import regwin_pkg::*;
#(
    parameter int NWIN = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ARCH_W-1:0]    rd_a_idx,
    input logic [XLEN-1:0]      rd_a_data,
    input logic [ARCH_W-1:0]    rd_b_idx,
    input logic [XLEN-1:0]      rd_b_data,
    input logic                 wr_en,
    input logic [ARCH_W-1:0]    wr_idx,
    input logic [XLEN-1:0]      wr_data,
    input logic                 save_req,
    input logic                 restore_req,
    input logic [PTR_OUT_W-1:0] cwp,
    input logic                 ovf_trap,
    input logic                 unf_trap
);

    localparam logic [PTR_OUT_W-1:0] TOP = PTR_OUT_W'(NWIN - 1);

    a_r6_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cwp <= TOP);

    a_r2_zero_port_a: assert property (@(posedge clk) disable iff (!rst_n)
        rd_a_idx == '0 |-> rd_a_data == '0);

    a_r2_zero_port_b: assert property (@(posedge clk) disable iff (!rst_n)
        rd_b_idx == '0 |-> rd_b_data == '0);

    a_r6_save_step: assert property (@(posedge clk) disable iff (!rst_n)
        save_req && !restore_req |=> ovf_trap ||
            cwp == (($past(cwp) == '0) ? TOP : $past(cwp) - 5'd1));

    a_r7_restore_step: assert property (@(posedge clk) disable iff (!rst_n)
        restore_req && !save_req |=> unf_trap ||
            cwp == (($past(cwp) == TOP) ? 5'd0 : $past(cwp) + 5'd1));

    a_r8_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_trap |-> $past(save_req && !restore_req) && cwp == $past(cwp));

    a_r9_unf_cause: assert property (@(posedge clk) disable iff (!rst_n)
        unf_trap |-> $past(restore_req && !save_req) && cwp == $past(cwp));

    a_r8_single_trap: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_trap && unf_trap));

    a_r10_conflict: assert property (@(posedge clk) disable iff (!rst_n)
        save_req && restore_req |=> !ovf_trap && !unf_trap && $stable(cwp));

    a_r11_bypass_a: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_idx == rd_a_idx && wr_idx != '0 |-> rd_a_data == wr_data);

endmodule

bind regwin_rf regwin_rf_chk #(.NWIN(NWIN)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_a_idx    (rd_a_idx),
    .rd_a_data   (rd_a_data),
    .rd_b_idx    (rd_b_idx),
    .rd_b_data   (rd_b_data),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .save_req    (save_req),
    .restore_req (restore_req),
    .cwp         (cwp),
    .ovf_trap    (ovf_trap),
    .unf_trap    (unf_trap)
);

// File: tb/regwin_rf_tb_top.sv
module regwin_rf_tb_top;

    localparam int NWIN = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
    logic        wr_en = 1'b0, save_req = 1'b0, restore_req = 1'b0;
    logic [NWIN-1:0] win_invalid = '0;
    logic [4:0]  cwp;
    logic        ovf_trap, unf_trap;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    regwin_rf #(.NWIN(NWIN)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .save_req(save_req), .restore_req(restore_req),
        .win_invalid(win_invalid),
        .cwp(cwp), .ovf_trap(ovf_trap), .unf_trap(unf_trap)
    );

    // {cmd[1:0] (bit0 save, bit1 restore), we, widx, wdata, ridx, expected read, expected cwp}
    localparam int NVEC = 13;
    localparam logic [81:0] VEC [NVEC] = '{
        {2'd0, 1'b1, 5'd1,  32'h1111_1111, 5'd1,  32'h1111_1111, 5'd0}, // R3
        {2'd0, 1'b1, 5'd16, 32'hA0A0_A0A0, 5'd16, 32'hA0A0_A0A0, 5'd0}, // R4
        {2'd0, 1'b1, 5'd8,  32'hB0B0_B0B0, 5'd8,  32'hB0B0_B0B0, 5'd0}, // R5
        {2'd0, 1'b1, 5'd24, 32'hC0C0_C0C0, 5'd24, 32'hC0C0_C0C0, 5'd0}, // R4
        {2'd1, 1'b0, 5'd0,  32'h0,         5'd24, 32'hB0B0_B0B0, 5'd7}, // R5 R6 wrap
        {2'd0, 1'b0, 5'd0,  32'h0,         5'd16, 32'h0,         5'd7}, // R4 private local
        {2'd0, 1'b1, 5'd16, 32'hD7D7_D7D7, 5'd16, 32'hD7D7_D7D7, 5'd7}, // R4
        {2'd0, 1'b0, 5'd0,  32'h0,         5'd1,  32'h1111_1111, 5'd7}, // R3
        {2'd2, 1'b0, 5'd0,  32'h0,         5'd16, 32'hA0A0_A0A0, 5'd0}, // R7 wrap
        {2'd0, 1'b0, 5'd0,  32'h0,         5'd8,  32'hB0B0_B0B0, 5'd0}, // R5
        {2'd2, 1'b0, 5'd0,  32'h0,         5'd8,  32'hC0C0_C0C0, 5'd1}, // R5 R7
        {2'd0, 1'b1, 5'd0,  32'hFFFF_FFFF, 5'd0,  32'h0,         5'd1}, // R2
        {2'd1, 1'b0, 5'd0,  32'h0,         5'd16, 32'hA0A0_A0A0, 5'd0}  // R6
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, let one edge pass, release commands, point reads at ridx
    task automatic step(input logic [1:0] cmd, input logic we, input logic [4:0] widx,
                        input logic [31:0] wdata, input logic [4:0] ridx);
        @(negedge clk);
        save_req    = cmd[0];
        restore_req = cmd[1];
        wr_en       = we;
        wr_idx      = widx;
        wr_data     = wdata;
        @(posedge clk);
        #1;
        save_req    = 1'b0;
        restore_req = 1'b0;
        wr_en       = 1'b0;
        rd_a_idx    = ridx;
        rd_b_idx    = ridx;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        rd_a_idx = 5'd31;
        rd_b_idx = 5'd5;
        #1;
        check("R1 cwp in reset", {27'd0, cwp}, 32'd0);
        check("R1 traps in reset", {30'd0, ovf_trap, unf_trap}, 32'd0);
        check("R1 r31 in reset", rd_a_data, 32'd0);
        check("R1 r5 in reset", rd_b_data, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        check("R1 cwp after reset", {27'd0, cwp}, 32'd0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][81:80], VEC[i][79], VEC[i][78:74], VEC[i][73:42], VEC[i][41:37]);
            check($sformatf("R4 vec%0d port a", i), rd_a_data, VEC[i][36:5]);
            check($sformatf("R4 vec%0d port b", i), rd_b_data, VEC[i][36:5]);
            check($sformatf("R6 vec%0d cwp", i), {27'd0, cwp}, {27'd0, VEC[i][4:0]});
            check($sformatf("R8 vec%0d no trap", i), {30'd0, ovf_trap, unf_trap}, 32'd0);
        end

        // R11: same-cycle write and read return the new value, then it is kept
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 5'd17; wr_data = 32'h55AA_1234;
        rd_a_idx = 5'd17; rd_b_idx = 5'd17;
        #1;
        check("R11 bypass port a", rd_a_data, 32'h55AA_1234);
        check("R11 bypass port b", rd_b_data, 32'h55AA_1234);
        @(posedge clk);
        #1; wr_en = 1'b0; #1;
        check("R11 stored", rd_a_data, 32'h55AA_1234);

        // R2: write to r0 with same-cycle read of r0
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 5'd0; wr_data = 32'hDEAD_BEEF; rd_a_idx = 5'd0;
        #1;
        check("R2 r0 same cycle", rd_a_data, 32'd0);
        @(posedge clk);
        #1; wr_en = 1'b0; #1;
        check("R2 r0 after write", rd_a_data, 32'd0);

        // R12: write together with save lands in the old window
        step(2'd1, 1'b1, 5'd18, 32'h0BAD_F00D, 5'd18);
        check("R12 cwp after save", {27'd0, cwp}, 32'd7);
        check("R12 new window empty", rd_a_data, 32'd0);
        step(2'd2, 1'b0, 5'd0, 32'd0, 5'd18);
        check("R12 old window holds write", rd_a_data, 32'h0BAD_F00D);

        // R8: overflow trap
        win_invalid = 8'h80;
        step(2'd1, 1'b0, 5'd0, 32'd0, 5'd16);
        check("R8 ovf raised", {31'd0, ovf_trap}, 32'd1);
        check("R8 unf quiet", {31'd0, unf_trap}, 32'd0);
        check("R8 cwp held", {27'd0, cwp}, 32'd0);
        check("R8 window unchanged", rd_a_data, 32'hA0A0_A0A0);
        step(2'd0, 1'b0, 5'd0, 32'd0, 5'd16);
        check("R8 ovf one cycle", {31'd0, ovf_trap}, 32'd0);

        // R9: underflow trap
        win_invalid = 8'h02;
        step(2'd2, 1'b0, 5'd0, 32'd0, 5'd16);
        check("R9 unf raised", {31'd0, unf_trap}, 32'd1);
        check("R9 ovf quiet", {31'd0, ovf_trap}, 32'd0);
        check("R9 cwp held", {27'd0, cwp}, 32'd0);
        step(2'd0, 1'b0, 5'd0, 32'd0, 5'd16);
        check("R9 unf one cycle", {31'd0, unf_trap}, 32'd0);

        // R6: a save to a valid window while other bits are set
        step(2'd1, 1'b0, 5'd0, 32'd0, 5'd16);
        check("R6 save valid target", {27'd0, cwp}, 32'd7);
        check("R6 no trap", {30'd0, ovf_trap, unf_trap}, 32'd0);
        step(2'd2, 1'b0, 5'd0, 32'd0, 5'd16);
        check("R7 back to 0", {27'd0, cwp}, 32'd0);

        // R10: save and restore together
        win_invalid = '0;
        step(2'd3, 1'b0, 5'd0, 32'd0, 5'd16);
        check("R10 cwp unchanged", {27'd0, cwp}, 32'd0);
        check("R10 no trap", {30'd0, ovf_trap, unf_trap}, 32'd0);
        check("R10 window unchanged", rd_a_data, 32'hA0A0_A0A0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule